// File: doc/BRIEF.md
# Hit-Driven Pixel Column Readout with Time-over-Threshold Stamps

This block is one pixel column of a detector readout that sends data only when a photon arrives, never as a periodic frame. Every pixel watches its own discriminator line and a shared free-running time-stamp bus. A discriminator pulse first passes a two-flop synchronizer. When the synchronized pulse rises, the pixel stores the current stamp as the arrival time. When it falls, the pixel stores the pulse width in stamp counts. The pixel then holds this hit until it has been read out.

A priority picker drains the held hits one by one onto a single column output. It uses a valid/ready handshake and always takes the lowest pixel index first. Each output word packs the pixel address, the arrival stamp and the pulse width. The pulse width is the energy measure. At the intended 50 MHz stamp rate one count is 20 ns.

Top module: `tot_column_drain`

## Requirements
- R1: The arrival stamp in a word is the value of `ts_i` sampled on the third rising clock edge after `disc_i` of that pixel rises. Two of those edges are spent in the synchronizer.
- R2: The width field equals the stamp at the falling edge minus the stamp at the rising edge, taken modulo 2^TS_W. So a pulse held high for W clock cycles gives W, even when the stamp counter wraps during the pulse.
- R3: A word is presented only for a pixel that holds a hit. With no held hit, `col_valid_o` stays low.
- R4: When no word is stalled, the word presented belongs to the lowest-index pixel that holds a hit.
- R5: A hit is delivered exactly once. Its pixel stops holding it on the clock edge where `col_valid_o` and `col_ready_i` are both high.
- R6: While a pixel holds an undelivered hit, new discriminator pulses on that pixel are ignored. From the cycle after delivery the pixel accepts a new pulse.
- R7: While `col_valid_o` is high and `col_ready_i` is low, `col_valid_o` and `col_data_o` keep their values on the next cycle, even if a lower-index pixel gets a hit meanwhile.
- R8: During reset and right after reset, `col_valid_o` is low.
- R9: `col_data_o` is laid out as {pixel index in bits [25:20], arrival stamp in [19:10], width in [9:0]} at the default sizes. The index is the position of the pixel's bit in `disc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The stamp bus advances with it. |
| rst_n | input | 1 | Reset, active low. Asserts asynchronously and releases synchronously. |
| ts_i | input | TS_W (10) | Shared free-running time stamp |
| disc_i | input | NPIX (64) | Discriminator outputs, one bit per pixel, asynchronous |
| col_ready_i | input | 1 | The consumer accepts the presented word |
| col_valid_o | output | 1 | A word is presented |
| col_data_o | output | IDX_W+2*TS_W (26) | {pixel index, arrival stamp, width} |

## Verification
An edge on a discriminator line takes two clock edges to cross the synchronizer, and its stamp is latched on the third edge. The bench therefore predicts the arrival stamp as the stamp it sees when it drives the rise, plus two. It predicts the width as the number of cycles the line was held high. A held hit appears on `col_valid_o` the cycle after its falling stamp is latched. All inputs change one time unit after a rising edge, and outputs are sampled on the falling edge. Each accepted word is therefore checked against its predicted fields in the half cycle before the edge that takes it. Stall checks and order checks compare the whole sequence of delivered words once the column has drained.

// File: rtl/tot_column_pkg.sv
package tot_column_pkg;

  typedef enum logic [1:0] {
    PX_ARMED = 2'd0,
    PX_HIGH  = 2'd1,
    PX_HELD  = 2'd2
  } px_state_e;

endpackage

// File: rtl/tot_pixel.sv
module tot_pixel
  import tot_column_pkg::*;
#(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disc_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            drain_i,
  output logic            hit_o,
  output logic [TS_W-1:0] lead_o,
  output logic [TS_W-1:0] width_o
);

  logic            sync1_q, sync2_q, prev_q;
  logic            rise, fall;
  px_state_e       state_q, state_d;
  logic [TS_W-1:0] lead_q, lead_d;
  logic [TS_W-1:0] width_q, width_d;
  logic            lead_en, width_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= disc_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    state_d  = state_q;
    lead_d   = lead_q;
    width_d  = width_q;
    lead_en  = 1'b0;
    width_en = 1'b0;
    unique case (state_q)
      PX_ARMED: begin
        if (rise) begin
          lead_d  = ts_i;
          lead_en = 1'b1;
          state_d = PX_HIGH;
        end
      end
      PX_HIGH: begin
        if (fall) begin
          width_d  = ts_i - lead_q;
          width_en = 1'b1;
          state_d  = PX_HELD;
        end
      end
      PX_HELD: begin
        if (drain_i) state_d = PX_ARMED;
      end
      default: state_d = PX_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PX_ARMED;
      lead_q  <= '0;
      width_q <= '0;
    end else begin
      state_q <= state_d;
      if (lead_en)  lead_q  <= lead_d;
      if (width_en) width_q <= width_d;
    end
  end

  assign hit_o   = (state_q == PX_HELD);
  assign lead_o  = lead_q;
  assign width_o = width_q;

  AST_DRAIN_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> hit_o); // R3
  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |=> !hit_o); // R5
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o && !drain_i |=> hit_o && $stable(lead_o) && $stable(width_o)); // R6

endmodule

// File: rtl/drain_picker.sv
module drain_picker #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hit_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     drain_o
);

  logic             any_hit;
  logic [IDX_W-1:0] low_idx;
  logic             lock_q, lock_d;
  logic [IDX_W-1:0] lock_idx_q, lock_idx_d;
  logic             lock_idx_en;
  logic             accept;

  always_comb begin
    low_idx = '0;
    any_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        low_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign valid_o = lock_q | any_hit;
  assign idx_o   = lock_q ? lock_idx_q : low_idx;
  assign accept  = valid_o & ready_i;

  always_comb begin
    lock_d      = lock_q;
    lock_idx_d  = lock_idx_q;
    lock_idx_en = 1'b0;
    if (accept) begin
      lock_d = 1'b0;
    end else if (valid_o && !lock_q) begin
      lock_d      = 1'b1;
      lock_idx_d  = low_idx;
      lock_idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (lock_idx_en) lock_idx_q <= lock_idx_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_drain
    assign drain_o[g] = accept && (idx_o == IDX_W'(g));
  end

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !lock_q |-> ((hit_i & ((N'(1) << idx_o) - N'(1))) == '0)); // R4
  AST_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_o)); // R5
  AST_VALID_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> hit_i[idx_o]); // R3
  AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(idx_o)); // R7

endmodule

// File: rtl/word_select.sv
module word_select #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int TS_W  = 10
) (
  input  logic [N-1:0][TS_W-1:0] lead_i,
  input  logic [N-1:0][TS_W-1:0] width_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [IDX_W+2*TS_W-1:0] word_o
);

  logic [TS_W-1:0] lead_sel, width_sel;

  always_comb begin
    lead_sel  = '0;
    width_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IDX_W'(i)) begin
        lead_sel  = lead_i[i];
        width_sel = width_i[i];
      end
    end
  end

  assign word_o = {idx_i, lead_sel, width_sel};

endmodule

// File: rtl/tot_column_drain.sv
module tot_column_drain #(
  parameter int NPIX = 64,
  parameter int TS_W = 10,
  localparam int IDX_W  = $clog2(NPIX),
  localparam int WORD_W = IDX_W + 2 * TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [NPIX-1:0]   disc_i,
  input  logic              col_ready_i,
  output logic              col_valid_o,
  output logic [WORD_W-1:0] col_data_o
);

  logic                         rst_meta_q, rst_sync_q;
  logic [NPIX-1:0]              hit;
  logic [NPIX-1:0]              drain;
  logic [NPIX-1:0][TS_W-1:0]    lead_all;
  logic [NPIX-1:0][TS_W-1:0]    width_all;
  logic [IDX_W-1:0]             pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    tot_pixel #(.TS_W(TS_W)) u_pixel (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .disc_i  (disc_i[p]),
      .ts_i    (ts_i),
      .drain_i (drain[p]),
      .hit_o   (hit[p]),
      .lead_o  (lead_all[p]),
      .width_o (width_all[p])
    );
  end

  drain_picker #(.N(NPIX), .IDX_W(IDX_W)) u_picker (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .hit_i   (hit),
    .ready_i (col_ready_i),
    .valid_o (col_valid_o),
    .idx_o   (pick_idx),
    .drain_o (drain)
  );

  word_select #(.N(NPIX), .IDX_W(IDX_W), .TS_W(TS_W)) u_select (
    .lead_i  (lead_all),
    .width_i (width_all),
    .idx_i   (pick_idx),
    .word_o  (col_data_o)
  );

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    col_valid_o && !col_ready_i |=> col_valid_o && $stable(col_data_o)); // R7
  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_sync_q |-> !col_valid_o); // R8

endmodule

// File: tb/tot_column_drain_bench.sv
module tot_column_drain_bench;

  localparam int NPIX = 64;
  localparam int TS_W = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  ts;
  logic [63:0] disc;
  logic        ready;
  logic        valid;
  logic [25:0] data;

  int checks = 0;
  int errors = 0;

  bit       exp_pend [NPIX];
  bit [9:0] exp_lead [NPIX];
  bit [9:0] exp_width[NPIX];
  int       obs_idx[$];
  int       obs_width[$];
  int       obs_lead[$];

  always #2 clk = ~clk;

  tot_column_drain u_tot_column_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_i        (ts),
    .disc_i      (disc),
    .col_ready_i (ready),
    .col_valid_o (valid),
    .col_data_o  (data)
  );

  always_ff @(posedge clk) ts <= ts + 10'd1;

  function automatic bit [9:0] f_lead(input bit [9:0] ts_at_drive);
    return ts_at_drive + 10'd2;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: accepted words checked against the model (R1 R2 R9 R3 R6)
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      automatic int a = int'(data[25:20]);
      obs_idx.push_back(a);
      obs_lead.push_back(int'(data[19:10]));
      obs_width.push_back(int'(data[9:0]));
      check(exp_pend[a], "R3/R6 unexpected word for pixel", a, -1);
      if (exp_pend[a]) begin
        check(data[19:10] == exp_lead[a], "R1 arrival stamp", int'(data[19:10]), int'(exp_lead[a]));
        check(data[9:0] == exp_width[a], "R2 width", int'(data[9:0]), int'(exp_width[a]));
        exp_pend[a] = 1'b0;
      end
    end
  end

  task automatic pulse(input int p, input int w, input bit expect_word);
    disc[p] = 1'b1;
    if (expect_word) begin
      exp_pend[p]  = 1'b1;
      exp_lead[p]  = f_lead(ts);
      exp_width[p] = 10'(w);
    end
    repeat (w) step();
    disc[p] = 1'b0;
  endtask

  task automatic check_drained(input string tag);
    int left = 0;
    for (int i = 0; i < NPIX; i++) if (exp_pend[i]) left++;
    check(left == 0, {tag, " R5 words still owed"}, left, 0);
    check(valid == 1'b0, {tag, " R3 valid with nothing held"}, int'(valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20210915));
    rst_n = 1'b0;
    ts    = '0;
    disc  = '0;
    ready = 1'b0;
    for (int i = 0; i < NPIX; i++) exp_pend[i] = 1'b0;
    repeat (4) step();
    check(valid == 1'b0, "R8 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (4) step();
    check(valid == 1'b0, "R8 valid after reset", int'(valid), 0);

    // R1 R2 R9: single pixel
    ready = 1'b1;
    pulse(7, 5, 1'b1);
    repeat (10) step();
    check(obs_idx.size() == 1 && obs_idx[0] == 7, "R9 address field", obs_idx.size() > 0 ? obs_idx[0] : -1, 7);
    check_drained("single");

    // R4: simultaneous pulses drain lowest index first
    obs_idx.delete();
    disc[40] = 1'b1; disc[3] = 1'b1; disc[20] = 1'b1;
    foreach (exp_pend[i]) if (i == 40 || i == 3 || i == 20) begin
      exp_pend[i] = 1'b1; exp_lead[i] = f_lead(ts); exp_width[i] = 10'd6;
    end
    repeat (6) step();
    disc = '0;
    repeat (12) step();
    check(obs_idx.size() == 3, "R4 word count", obs_idx.size(), 3);
    if (obs_idx.size() == 3) begin
      check(obs_idx[0] == 3,  "R4 first",  obs_idx[0], 3);
      check(obs_idx[1] == 20, "R4 second", obs_idx[1], 20);
      check(obs_idx[2] == 40, "R4 third",  obs_idx[2], 40);
    end
    check_drained("order");

    // R7: stalled word holds while a lower index arrives
    obs_idx.delete();
    ready = 1'b0;
    pulse(30, 4, 1'b1);
    repeat (5) step();
    check(valid && data[25:20] == 6'd30, "R7 stalled word present", int'(data[25:20]), 30);
    pulse(2, 3, 1'b1);
    repeat (6) step();
    check(valid && data[25:20] == 6'd30, "R7 stalled word kept", int'(data[25:20]), 30);
    check(data[9:0] == 10'd4, "R7 stalled width kept", int'(data[9:0]), 4);
    ready = 1'b1;
    repeat (4) step();
    check(obs_idx.size() == 2 && obs_idx[0] == 30 && obs_idx[1] == 2, "R7 drain order",
          obs_idx.size() > 0 ? obs_idx[0] : -1, 30);
    check_drained("stall");

    // R6: pulses ignored while held; re-armed after delivery
    obs_idx.delete(); obs_width.delete();
    ready = 1'b0;
    pulse(5, 4, 1'b1);
    repeat (6) step();
    pulse(5, 9, 1'b0);
    repeat (8) step();
    ready = 1'b1;
    repeat (6) step();
    check(obs_idx.size() == 1, "R6 one word while held", obs_idx.size(), 1);
    check(obs_width.size() > 0 && obs_width[0] == 4, "R6 first width kept",
          obs_width.size() > 0 ? obs_width[0] : -1, 4);
    pulse(5, 6, 1'b1);
    repeat (8) step();
    check(obs_idx.size() == 2, "R6 re-armed word", obs_idx.size(), 2);
    check_drained("rearm");

    // R2: stamp wraps inside the pulse
    obs_lead.delete(); obs_width.delete();
    while (ts != 10'd1018) step();
    pulse(9, 9, 1'b1);
    repeat (8) step();
    check(obs_width.size() == 1 && obs_width[0] == 9, "R2 wrapped width",
          obs_width.size() > 0 ? obs_width[0] : -1, 9);
    check(obs_lead.size() == 1 && obs_lead[0] == 1020, "R1 lead before wrap",
          obs_lead.size() > 0 ? obs_lead[0] : -1, 1020);
    check_drained("wrap");

    // random rounds: many pixels, random widths, random back-pressure
    for (int r = 0; r < 20; r++) begin
      automatic bit [63:0] sel   = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      automatic int        st[NPIX];
      automatic int        wd[NPIX];
      for (int i = 0; i < NPIX; i++) begin
        st[i] = int'($urandom_range(0, 30));
        wd[i] = int'($urandom_range(1, 40));
      end
      for (int c = 0; c < 75; c++) begin
        ready = ($urandom_range(0, 3) != 0);
        for (int i = 0; i < NPIX; i++) begin
          if (sel[i] && c == st[i]) begin
            disc[i] = 1'b1;
            exp_pend[i]  = 1'b1;
            exp_lead[i]  = f_lead(ts);
            exp_width[i] = 10'(wd[i]);
          end
          if (sel[i] && c == st[i] + wd[i]) disc[i] = 1'b0;
        end
        step();
      end
      ready = 1'b1;
      repeat (80) step();
      check_drained("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule